// File: doc/BRIEF.md
# Receive Ring Buffer Manager

This block places incoming frames into a circular receive area of local memory. The area is divided into 256-byte pages and runs from a programmable first page up to, but not including, a programmable end page. The block keeps the write-page pointer, which marks where the next frame will be stored. The host owns a boundary pointer, which marks the last page it has finished reading.

When a frame starts, the first four bytes of its first page are reserved for a header. Frame bytes are stored from byte 4 onward, and a page step past the end page wraps back to the first page. When the frame ends, the block writes the header. The header holds the receive status, the link to the page where the following frame will start, and the stored byte count. The write-page pointer then moves to that link.

The block refuses to step onto the boundary page. If a frame would need that page, the frame is dropped and a sticky overwrite flag is raised. The write-page pointer then stays where it was. The host learns that the ring is empty when its read pointer equals the write-page pointer.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, `cur_page`, `boundary` and `ovw` read 0 and no memory write is issued.
- R2: Host register writes are decoded by offset and page select. With `reg_pg1`=0, offset 1 sets the first ring page, offset 2 the end page and offset 3 the boundary. With `reg_pg1`=1, offset 7 sets the write-page pointer. Any other combination changes nothing.
- R3: A frame accepted on `rx_start` stores its n-th byte at page `cur_page`, byte 4+n. Each byte is written one cycle after it is presented, at consecutive addresses within a page.
- R4: When a byte would fall past byte 255 of a page, it goes to byte 0 of the next page. The page after end-page minus 1 is the first ring page.
- R5: The header is written after `rx_end`, one byte per cycle, starting two cycles after `rx_end` is sampled. It goes to bytes 0..3 of the frame's first page, in this order: status, next-frame page, byte count low, byte count high.
- R6: The byte count in the header equals the number of bytes stored for the frame, CRC bytes included and header excluded.
- R7: The next-frame page is the page after the one holding the frame's last byte, with wrap. `cur_page` takes this value in the same cycle as the last header write.
- R8: The status byte carries `rx_status` in bits 3..0, with the upper bits zero. Bit 0 means intact, bit 1 CRC error, bit 2 alignment error and bit 3 FIFO overrun.
- R9: A frame is dropped when a byte needs a new page and that page equals the boundary. That byte and all later bytes of the frame are not written, no header is written, `cur_page` is unchanged and `ovw` is set.
- R10: A frame whose start finds `cur_page` equal to the boundary is dropped whole, and `ovw` is set.
- R11: `ovw` stays set until `ovw_clr` is pulsed. A new overwrite in the same cycle as `ovw_clr` wins.
- R12: `rx_start` is ignored while a frame or its header is in progress. `rx_valid` and `rx_end` are ignored outside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_pg1 | input | 1 | Register page select |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| rx_start | input | 1 | Frame start pulse |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_end | input | 1 | Frame end pulse |
| rx_status | input | 4 | Receive status at frame end |
| ovw_clr | input | 1 | Clear the overwrite flag |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 16 | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory write data |
| cur_page | output | 8 | Write-page pointer |
| boundary | output | 8 | Host boundary pointer |
| ovw | output | 1 | Sticky overwrite warning |

## Verification
Several kinds of frames are driven through the block:
- Short frames that fit in one page confirm the byte offset, the header placement and the link.
- A long frame that crosses the end page separates correct wrapping from a plain increment.
- A frame whose next page hits the boundary in mid-flight, and one that starts with the ring full, tell a mid-frame drop apart from a start-time drop. Each is checked by looking for the absent writes and the unchanged pointer.
- Random lengths and status values, with the host sometimes failing to consume, mix all these cases and check every header byte count.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
   localparam int HDR_BYTES = 4;
   localparam int HDR_IDX_W = 2;

   localparam int OFF_FIRST = 1;
   localparam int OFF_END   = 2;
   localparam int OFF_BND   = 3;
   localparam int OFF_WRPG  = 7;

   typedef enum logic [1:0] {
      WS_IDLE,
      WS_RECV,
      WS_DROP,
      WS_HDR
   } wr_state_e;
endpackage

// File: rtl/rbm_pagereg.sv
module rbm_pagereg
   import rbm_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int REG_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_pg1,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [PAGE_W-1:0] wr_data,
   input  logic              cur_upd,
   input  logic [PAGE_W-1:0] cur_next,
   output logic [PAGE_W-1:0] first_pg,
   output logic [PAGE_W-1:0] end_pg,
   output logic [PAGE_W-1:0] bnd_pg,
   output logic [PAGE_W-1:0] cur_pg
);
   logic hit_first, hit_end, hit_bnd, hit_cur;

   always_comb begin
      hit_first = wr_en && !wr_pg1 && (wr_addr == REG_AW'(OFF_FIRST));
      hit_end   = wr_en && !wr_pg1 && (wr_addr == REG_AW'(OFF_END));
      hit_bnd   = wr_en && !wr_pg1 && (wr_addr == REG_AW'(OFF_BND));
      hit_cur   = wr_en &&  wr_pg1 && (wr_addr == REG_AW'(OFF_WRPG));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_pg <= '0;
         end_pg   <= '0;
         bnd_pg   <= '0;
         cur_pg   <= '0;
      end else begin
         if (hit_first) first_pg <= wr_data;
         if (hit_end)   end_pg   <= wr_data;
         if (hit_bnd)   bnd_pg   <= wr_data;
         if (hit_cur)        cur_pg <= wr_data;
         else if (cur_upd)   cur_pg <= cur_next;
      end
   end

   // R2: a host write to the write-page pointer lands on the next cycle
   a_r2_cur_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_pg1 && wr_addr == REG_AW'(OFF_WRPG)) |=> (cur_pg == $past(wr_data)));
endmodule

// File: rtl/rbm_writer.sv
module rbm_writer
   import rbm_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int OFS_W  = 8,
   parameter int DATA_W = 8,
   parameter int LEN_W  = 16,
   parameter int ST_W   = 4,
   localparam int ADDR_W = PAGE_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAGE_W-1:0] first_pg,
   input  logic [PAGE_W-1:0] end_pg,
   input  logic [PAGE_W-1:0] bnd_pg,
   input  logic [PAGE_W-1:0] cur_pg,
   input  logic              rx_start,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_end,
   input  logic [ST_W-1:0]   rx_status,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              cur_upd,
   output logic [PAGE_W-1:0] cur_next,
   output logic              ovw_set
);
   wr_state_e              state;
   logic [PAGE_W-1:0]      base_pg, wr_pg, link_pg, nxt_pg;
   logic [OFS_W-1:0]       ofs;
   logic [LEN_W-1:0]       len;
   logic [ST_W-1:0]        stat_q;
   logic [HDR_IDX_W-1:0]   hidx;
   logic [DATA_W-1:0]      hdr_byte;
   logic                   new_page, mid_hit, start_hit;

   function automatic logic [PAGE_W-1:0] pg_step(input logic [PAGE_W-1:0] p,
                                                 input logic [PAGE_W-1:0] lo,
                                                 input logic [PAGE_W-1:0] hi);
      logic [PAGE_W-1:0] n;
      n = p + 1'b1;
      return (n == hi) ? lo : n;
   endfunction

   always_comb begin
      nxt_pg    = pg_step(wr_pg, first_pg, end_pg);
      new_page  = (ofs == '0);
      mid_hit   = new_page && (nxt_pg == bnd_pg);
      start_hit = (cur_pg == bnd_pg);
      ovw_set   = ((state == WS_IDLE) && rx_start && start_hit) ||
                  ((state == WS_RECV) && !rx_end && rx_valid && mid_hit);
      cur_upd   = (state == WS_HDR) && (hidx == HDR_IDX_W'(HDR_BYTES - 1));
      cur_next  = link_pg;
      unique case (hidx)
         2'd0:    hdr_byte = DATA_W'(stat_q);
         2'd1:    hdr_byte = DATA_W'(link_pg);
         2'd2:    hdr_byte = len[DATA_W-1:0];
         default: hdr_byte = len[LEN_W-1:LEN_W-DATA_W];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= WS_IDLE;
         base_pg   <= '0;
         wr_pg     <= '0;
         link_pg   <= '0;
         ofs       <= '0;
         len       <= '0;
         stat_q    <= '0;
         hidx      <= '0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= 1'b0;
         unique case (state)
            WS_IDLE: begin
               if (rx_start) begin
                  if (start_hit) begin
                     state <= WS_DROP;
                  end else begin
                     state   <= WS_RECV;
                     base_pg <= cur_pg;
                     wr_pg   <= cur_pg;
                     ofs     <= OFS_W'(HDR_BYTES);
                     len     <= '0;
                  end
               end
            end
            WS_RECV: begin
               if (rx_end) begin
                  state   <= WS_HDR;
                  hidx    <= '0;
                  link_pg <= nxt_pg;
                  stat_q  <= rx_status;
               end else if (rx_valid) begin
                  if (mid_hit) begin
                     state <= WS_DROP;
                  end else begin
                     mem_we    <= 1'b1;
                     mem_wdata <= rx_data;
                     if (new_page) begin
                        wr_pg    <= nxt_pg;
                        mem_addr <= {nxt_pg, ofs};
                     end else begin
                        mem_addr <= {wr_pg, ofs};
                     end
                     ofs <= ofs + 1'b1;
                     len <= len + 1'b1;
                  end
               end
            end
            WS_DROP: begin
               if (rx_end) state <= WS_IDLE;
            end
            WS_HDR: begin
               mem_we    <= 1'b1;
               mem_addr  <= {base_pg, OFS_W'(hidx)};
               mem_wdata <= hdr_byte;
               hidx      <= hidx + 1'b1;
               if (cur_upd) state <= WS_IDLE;
            end
            default: state <= WS_IDLE;
         endcase
      end
   end

   // R9: no write ever lands in the page the host still owns
   a_r9_no_bnd_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[ADDR_W-1:OFS_W] != bnd_pg));

   // R9: a dropped frame produces no memory traffic
   a_r9_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WS_DROP) |=> !mem_we);

   // R5: every header cycle results in a memory write
   a_r5_hdr_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WS_HDR) |=> mem_we);
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
   import rbm_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int OFS_W  = 8,
   parameter int DATA_W = 8,
   parameter int LEN_W  = 16,
   parameter int ST_W   = 4,
   parameter int REG_AW = 4,
   localparam int ADDR_W = PAGE_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_pg1,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [PAGE_W-1:0] reg_wdata,
   input  logic              rx_start,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_end,
   input  logic [ST_W-1:0]   rx_status,
   input  logic              ovw_clr,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [PAGE_W-1:0] cur_page,
   output logic [PAGE_W-1:0] boundary,
   output logic              ovw
);
   if (PAGE_W != DATA_W) begin : g_bad_page_w
      $error("page pointer must fit one header byte");
   end
   if (LEN_W != 2 * DATA_W) begin : g_bad_len_w
      $error("byte count must span two header bytes");
   end
   if (ST_W > DATA_W) begin : g_bad_st_w
      $error("status wider than a header byte");
   end
   if (OFS_W <= HDR_IDX_W) begin : g_bad_ofs_w
      $error("page too small for the header");
   end

   logic [PAGE_W-1:0] first_pg, end_pg;
   logic              cur_upd, ovw_set;
   logic [PAGE_W-1:0] cur_next;
   logic              ovw_q;

   rbm_pagereg #(.PAGE_W(PAGE_W), .REG_AW(REG_AW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we),
      .wr_pg1   (reg_pg1),
      .wr_addr  (reg_addr),
      .wr_data  (reg_wdata),
      .cur_upd  (cur_upd),
      .cur_next (cur_next),
      .first_pg (first_pg),
      .end_pg   (end_pg),
      .bnd_pg   (boundary),
      .cur_pg   (cur_page)
   );

   rbm_writer #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .DATA_W(DATA_W),
                .LEN_W(LEN_W), .ST_W(ST_W)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .first_pg  (first_pg),
      .end_pg    (end_pg),
      .bnd_pg    (boundary),
      .cur_pg    (cur_page),
      .rx_start  (rx_start),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_end    (rx_end),
      .rx_status (rx_status),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .cur_upd   (cur_upd),
      .cur_next  (cur_next),
      .ovw_set   (ovw_set)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        ovw_q <= 1'b0;
      else if (ovw_set)  ovw_q <= 1'b1;
      else if (ovw_clr)  ovw_q <= 1'b0;
   end
   assign ovw = ovw_q;

   // R11: the warning holds until the host clears it
   a_r11_ovw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovw_q && !ovw_clr) |=> ovw_q);

   // R11: a new overwrite always leaves the flag set
   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ovw_set |=> ovw_q);
endmodule

// File: tb/tb_rx_ring_mgr.sv
module tb_rx_ring_mgr;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_we, reg_pg1;
   logic [3:0]  reg_addr;
   logic [7:0]  reg_wdata;
   logic        rx_start, rx_valid, rx_end, ovw_clr;
   logic [7:0]  rx_data;
   logic [3:0]  rx_status;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  cur_page, boundary;
   logic        ovw;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] m_first, m_end, m_bnd, m_cur;
   bit m_ovw;

   always #10 clk = ~clk;

   rx_ring_mgr dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_pg1(reg_pg1),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rx_start(rx_start),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
      .rx_status(rx_status), .ovw_clr(ovw_clr), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_page(cur_page),
      .boundary(boundary), .ovw(ovw)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pinc(input logic [7:0] p);
      return (p + 8'd1 == m_end) ? m_first : p + 8'd1;
   endfunction

   function automatic logic [7:0] pdec(input logic [7:0] p);
      return (p == m_first) ? m_end - 8'd1 : p - 8'd1;
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic host_wr(input bit pg1, input logic [3:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_pg1 = pg1; reg_addr = a; reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic set_bnd(input logic [7:0] b);
      host_wr(1'b0, 4'd3, b);
      m_bnd = b;
   endtask

   task automatic set_cur(input logic [7:0] c);
      host_wr(1'b1, 4'd7, c);
      m_cur = c;
   endtask

   task automatic clear_ovw();
      ovw_clr = 1'b1;
      tick();
      ovw_clr = 1'b0;
      m_ovw = 1'b0;
      chk(ovw == 1'b0, "R11", "ovw after clear", ovw, 0);
   endtask

   task automatic run_frame(input int n, input logic [3:0] st, input bit poke);
      logic [7:0] pg, ofs, base, b, ex;
      logic [15:0] cnt;
      bit drop;
      drop = (m_cur == m_bnd);
      pg = m_cur; base = m_cur; ofs = 8'd4; cnt = '0;
      rx_start = 1'b1;
      tick();
      rx_start = 1'b0;
      if (drop) begin
         m_ovw = 1'b1;
         chk(ovw == 1'b1, "R10", "ovw on full-ring start", ovw, 1);
      end
      for (int i = 0; i < n; i++) begin
         bit pagechg;
         pagechg = 1'b0;
         b = 8'($urandom);
         rx_valid = 1'b1; rx_data = b;
         if (!drop && ofs == 8'd0) begin
            if (pinc(pg) == m_bnd) begin
               drop = 1'b1;
               m_ovw = 1'b1;
            end else begin
               pg = pinc(pg);
               pagechg = 1'b1;
            end
         end
         tick();
         if (drop) begin
            chk(mem_we == 1'b0, "R9", "write while dropping", mem_we, 0);
            chk(ovw == m_ovw, "R9", "ovw while dropping", ovw, m_ovw);
         end else begin
            chk(mem_we && mem_addr == {pg, ofs} && mem_wdata == b,
                pagechg ? "R4" : "R3", "byte write addr",
                mem_we ? mem_addr : 32'hdead, {pg, ofs});
            ofs = ofs + 8'd1;
            cnt = cnt + 16'd1;
         end
      end
      rx_valid = 1'b0;
      rx_end = 1'b1; rx_status = st;
      tick();
      rx_end = 1'b0;
      if (!drop) begin
         for (int h = 0; h < 4; h++) begin
            if (h == 0) rx_start = poke;
            tick();
            rx_start = 1'b0;
            case (h)
               0: ex = {4'b0, st};
               1: ex = pinc(pg);
               2: ex = cnt[7:0];
               default: ex = cnt[15:8];
            endcase
            chk(mem_we && mem_addr == {base, 8'(h)}, "R5", "header addr",
                mem_we ? mem_addr : 32'hdead, {base, 8'(h)});
            chk(mem_wdata == ex, h == 0 ? "R8" : (h == 1 ? "R7" : "R6"),
                "header byte", mem_wdata, ex);
         end
         m_cur = pinc(pg);
         chk(cur_page == m_cur, "R7", "cur_page after header", cur_page, m_cur);
      end else begin
         chk(mem_we == 1'b0, "R9", "no header on drop", mem_we, 0);
         chk(cur_page == m_cur, "R9", "cur_page kept on drop", cur_page, m_cur);
      end
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'd2024);
      rst_n = 1'b0; reg_we = 0; reg_pg1 = 0; reg_addr = 0; reg_wdata = 0;
      rx_start = 0; rx_valid = 0; rx_end = 0; rx_data = 0; rx_status = 0; ovw_clr = 0;
      m_ovw = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(cur_page == 8'd0 && boundary == 8'd0, "R1", "pointers at reset",
          {cur_page, boundary}, 0);
      chk(ovw == 1'b0 && mem_we == 1'b0, "R1", "flags at reset", {ovw, mem_we}, 0);
      rst_n = 1'b1;
      tick();

      // R2: ring setup through the register offsets
      host_wr(1'b0, 4'd1, 8'h10); m_first = 8'h10;
      host_wr(1'b0, 4'd2, 8'h14); m_end = 8'h14;
      set_bnd(8'h13);
      set_cur(8'h10);
      chk(boundary == 8'h13, "R2", "boundary write", boundary, 8'h13);
      chk(cur_page == 8'h10, "R2", "write-page write", cur_page, 8'h10);
      host_wr(1'b1, 4'd3, 8'h55);
      chk(boundary == 8'h13 && cur_page == 8'h10, "R2", "unmapped write ignored",
          {boundary, cur_page}, 16'h1310);

      // short frame, then consume
      run_frame(10, 4'b0001, 1'b0);
      set_bnd(pdec(m_cur));
      // three-page frame whose link wraps to the first page, leaving the ring full
      run_frame(600, 4'b0011, 1'b0);
      // R10: start finds write page equal to boundary
      run_frame(20, 4'b0001, 1'b0);
      clear_ovw();

      // R4: frame straddling the end of the ring
      set_cur(8'h12);
      set_bnd(8'h11);
      run_frame(600, 4'b0101, 1'b0);

      // R9: mid-frame hit on the boundary page
      set_bnd(8'h13);
      run_frame(600, 4'b1001, 1'b0);
      clear_ovw();

      // R12: stray start during header, stray bytes and end outside a frame
      set_bnd(pdec(m_cur));
      run_frame(5, 4'b0001, 1'b1);
      for (int i = 0; i < 3; i++) begin
         rx_valid = 1'b1; rx_data = 8'hA5;
         tick();
         chk(mem_we == 1'b0, "R12", "byte outside frame", mem_we, 0);
      end
      rx_valid = 1'b0;
      rx_end = 1'b1;
      tick();
      rx_end = 1'b0;
      tick();
      chk(mem_we == 1'b0 && cur_page == m_cur, "R12", "end outside frame",
          {mem_we, cur_page}, {1'b0, m_cur});

      // random phase on a larger ring
      host_wr(1'b0, 4'd1, 8'h20); m_first = 8'h20;
      host_wr(1'b0, 4'd2, 8'h26); m_end = 8'h26;
      set_cur(8'h20);
      set_bnd(8'h25);
      for (int k = 0; k < 30; k++) begin
         run_frame(int'($urandom_range(0, 900)), 4'($urandom), 1'b0);
         if (m_ovw) begin
            chk(ovw == 1'b1, "R11", "ovw held", ovw, 1);
            clear_ovw();
         end
         if (($urandom % 4) != 0) set_bnd(pdec(m_cur));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule